// File: doc/BRIEF.md
# Pair-Set Detection and Classification Searcher

This block is the search phase of one pair-set controller in a multi-pair power-sourcing port. Once its controller is enabled and the port reports ready with no power applied, it requests a signature measurement and starts the detection timer. It also tells the supervising state machine to stop the timer that limits the time from connection check to detection. It then judges the measured signature. A bad signature leads either to a backoff wait or to an invalid-detection report. A good signature leads to a power-budget decision, either directly or through a classification step. That decision ends in a request for power delivery or for power denial.

The supervisor reads a latched failure flag. The flag is set whenever this pair set gives up: because detection failed, because the detection timer expired, or because the connection-to-detection window ran out before detection started. The flag stays set until a later detection reaches evaluation. The measurement hardware, the classification hardware and the timers sit outside the block. It only issues one-cycle timer start strobes and reads the timers' done flags.

Top module: `pairSearch`

## Requirements
- R1: After reset `detRequest`, `powerGrant`, `powerDeny`, `failFlag` and `validSig` are 0 and `reqPower` is 2. The block leaves idle only in a cycle where `psEnable`, `portReady` and not `powerApplied` are all true.
- R2: Leaving idle for detection raises `detRequest` for as long as detection runs. `startDetTimer` and `stopCc2det` each pulse for exactly the first cycle of detection. At that edge `reqPower` becomes 2 and `detClass` becomes 0.
- R3: With `detDone` high and `detTimerDone` low, the next edge enters evaluation. `startPonTimer` pulses for one cycle at that edge and `failFlag` clears at that same edge.
- R4: `sigCode` is encoded as 0 invalid, 1 valid, 2 open circuit and 3 treated as invalid. A non-valid code goes to a signature-invalid step. From there, `altB` high with a code other than 2 enters backoff, which pulses `startBackoffTimer` on entry and returns to idle when `backoffDone` is high. Every other case goes to invalid detection.
- R5: A valid signature with `classEvents` = 0, `availPower` >= `reqPower` and `errDelayDone` high raises `powerGrant` at the edge right after evaluation.
- R6: Any other valid signature passes through one classification cycle. It then raises `powerGrant` if `reqPower` <= `availPower` and `errDelayDone` is high, and otherwise raises `powerDeny`. The two are never high together.
- R7: Invalid detection is entered from detection when `detTimerDone` is high, from idle when `cc2detDone` is high with `psEnable`, and from the signature-invalid step. On entry `failFlag` is set, and it holds until the next evaluation entry.
- R8: `psEnable` low at an edge returns the block to idle, so `powerGrant`, `powerDeny` and `detRequest` are 0 after that edge.
- R9: `pdReqValid` high at an edge loads `pdReqPower` into `reqPower` and `pdClass` into `detClass`, except at the edge that enters detection.
- R10: `validSig` is set at the edge that leaves evaluation with a valid code, and cleared at every entry to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psEnable | input | 1 | Pair-set controller enable |
| portReady | input | 1 | Port ready to search |
| powerApplied | input | 1 | Power already present on the pair set |
| detDone | input | 1 | Signature measurement complete |
| detTimerDone | input | 1 | Detection timer expired |
| cc2detDone | input | 1 | Connection-to-detection window expired |
| backoffDone | input | 1 | Backoff timer expired |
| errDelayDone | input | 1 | Error-delay timer expired |
| sigCode | input | 2 | Signature result: 0 invalid, 1 valid, 2 open, 3 invalid |
| altB | input | 1 | Pair set is alternative B |
| classEvents | input | EVT_W | Number of classification events planned |
| pdReqValid | input | 1 | Load strobe for requested power and class |
| pdReqPower | input | PWR_W | Requested power from classification |
| pdClass | input | CLS_W | Detected class from classification |
| availPower | input | PWR_W | Available power budget |
| detRequest | output | 1 | Signature measurement request |
| startDetTimer | output | 1 | Detection timer start strobe |
| stopCc2det | output | 1 | Connection-to-detection timer stop strobe |
| startPonTimer | output | 1 | Power-on timer start strobe |
| startBackoffTimer | output | 1 | Backoff timer start strobe |
| failFlag | output | 1 | Latched search failure to the supervisor |
| validSig | output | 1 | Last evaluated signature was valid |
| powerGrant | output | 1 | Request to enter power delivery |
| powerDeny | output | 1 | Request to enter power denial |
| reqPower | output | PWR_W | Current requested power |
| detClass | output | CLS_W | Current detected class |

## Verification
A wrong state in the searcher shows at the ports within one to two edges. Evaluation is the only state that pulses the power-on strobe. The fast grant path reaches `powerGrant` one edge earlier than the classification path, so sampling `powerGrant` on the edge right after evaluation tells the two paths apart. A wrong branch out of the signature-invalid step shows up as either a backoff strobe or a set `failFlag` at the fourth edge of a search. A flag that is not latched, or that is cleared at the wrong time, shows up while the block idles after a failure or at the next evaluation edge.

// File: rtl/pair_search_pkg.sv
package pair_search_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_EVAL, ST_SIGBAD, ST_BACKOFF,
    ST_CLASS, ST_DETBAD, ST_POWER, ST_DENY
  } searchState_t;

  typedef enum logic [1:0] {
    SIG_INVALID = 2'd0, SIG_VALID = 2'd1, SIG_OPEN = 2'd2, SIG_RSVD = 2'd3
  } sigCode_t;

  // entry strobes from control to datapath, valid in the cycle before the edge
  typedef struct packed {
    logic enterStart;
    logic enterEval;
    logic enterBackoff;
    logic enterInvalid;
    logic enterIdle;
    logic sigOk;
  } ctrlStrobe_t;
endpackage

// File: rtl/searchCtrl.sv
module searchCtrl
  import pair_search_pkg::*;
#(
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             psEnable,
  input  logic             portReady,
  input  logic             powerApplied,
  input  logic             detDone,
  input  logic             detTimerDone,
  input  logic             cc2detDone,
  input  logic             backoffDone,
  input  logic             errDelayDone,
  input  logic [1:0]       sigCode,
  input  logic             altB,
  input  logic [EVT_W-1:0] classEvents,
  input  logic             budgetOk,
  output ctrlStrobe_t      strobe,
  output logic             detRequest,
  output logic             powerGrant,
  output logic             powerDeny
);
  searchState_t state, nextState;
  logic sigValid, sigOpen;

  assign sigValid = (sigCode == SIG_VALID);
  assign sigOpen  = (sigCode == SIG_OPEN);

  always_comb begin
    nextState = state;
    if (!psEnable) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (cc2detDone) nextState = ST_DETBAD;
                    else if (portReady && !powerApplied) nextState = ST_START;
        ST_START:   if (detTimerDone) nextState = ST_DETBAD;
                    else if (detDone) nextState = ST_EVAL;
        ST_EVAL:    if (!sigValid) nextState = ST_SIGBAD;
                    else if ((classEvents == '0) && budgetOk && errDelayDone) nextState = ST_POWER;
                    else nextState = ST_CLASS;
        ST_SIGBAD:  nextState = (altB && !sigOpen) ? ST_BACKOFF : ST_DETBAD;
        ST_BACKOFF: if (backoffDone) nextState = ST_IDLE;
        ST_CLASS:   nextState = (budgetOk && errDelayDone) ? ST_POWER : ST_DENY;
        ST_DETBAD:  nextState = ST_IDLE;
        ST_POWER:   nextState = ST_POWER;
        ST_DENY:    nextState = ST_DENY;
        default:    nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.enterStart   = (nextState == ST_START)   && (state != ST_START);
    strobe.enterEval    = (nextState == ST_EVAL)    && (state != ST_EVAL);
    strobe.enterBackoff = (nextState == ST_BACKOFF) && (state != ST_BACKOFF);
    strobe.enterInvalid = (nextState == ST_DETBAD)  && (state != ST_DETBAD);
    strobe.enterIdle    = (nextState == ST_IDLE)    && (state != ST_IDLE);
    strobe.sigOk        = (state == ST_EVAL) && sigValid;
  end

  assign detRequest = (state == ST_START);
  assign powerGrant = (state == ST_POWER);
  assign powerDeny  = (state == ST_DENY);
endmodule

// File: rtl/searchDatapath.sv
module searchDatapath
  import pair_search_pkg::*;
#(
  parameter int PWR_W       = 8,
  parameter int CLS_W       = 3,
  parameter int DEFAULT_REQ = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             pdReqValid,
  input  logic [PWR_W-1:0] pdReqPower,
  input  logic [CLS_W-1:0] pdClass,
  input  logic [PWR_W-1:0] availPower,
  output logic             budgetOk,
  output logic             startDetTimer,
  output logic             stopCc2det,
  output logic             startPonTimer,
  output logic             startBackoffTimer,
  output logic             failFlag,
  output logic             validSig,
  output logic [PWR_W-1:0] reqPower,
  output logic [CLS_W-1:0] detClass
);
  localparam logic [PWR_W-1:0] REQ_INIT = PWR_W'(DEFAULT_REQ);

  assign budgetOk = (availPower >= reqPower);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startDetTimer     <= 1'b0;
      stopCc2det        <= 1'b0;
      startPonTimer     <= 1'b0;
      startBackoffTimer <= 1'b0;
      failFlag          <= 1'b0;
      validSig          <= 1'b0;
      reqPower          <= REQ_INIT;
      detClass          <= '0;
    end else begin
      startDetTimer     <= strobe.enterStart;
      stopCc2det        <= strobe.enterStart;
      startPonTimer     <= strobe.enterEval;
      startBackoffTimer <= strobe.enterBackoff;

      if (strobe.enterStart) begin
        reqPower <= REQ_INIT;
        detClass <= '0;
      end else if (pdReqValid) begin
        reqPower <= pdReqPower;
        detClass <= pdClass;
      end

      if (strobe.enterEval)         failFlag <= 1'b0;
      else if (strobe.enterInvalid) failFlag <= 1'b1;

      if (strobe.enterIdle)  validSig <= 1'b0;
      else if (strobe.sigOk) validSig <= 1'b1;
    end
  end
endmodule

// File: rtl/pairSearch.sv
module pairSearch
  import pair_search_pkg::*;
#(
  parameter int PWR_W       = 8,
  parameter int CLS_W       = 3,
  parameter int EVT_W       = 3,
  parameter int DEFAULT_REQ = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             psEnable,
  input  logic             portReady,
  input  logic             powerApplied,
  input  logic             detDone,
  input  logic             detTimerDone,
  input  logic             cc2detDone,
  input  logic             backoffDone,
  input  logic             errDelayDone,
  input  logic [1:0]       sigCode,
  input  logic             altB,
  input  logic [EVT_W-1:0] classEvents,
  input  logic             pdReqValid,
  input  logic [PWR_W-1:0] pdReqPower,
  input  logic [CLS_W-1:0] pdClass,
  input  logic [PWR_W-1:0] availPower,
  output logic             detRequest,
  output logic             startDetTimer,
  output logic             stopCc2det,
  output logic             startPonTimer,
  output logic             startBackoffTimer,
  output logic             failFlag,
  output logic             validSig,
  output logic             powerGrant,
  output logic             powerDeny,
  output logic [PWR_W-1:0] reqPower,
  output logic [CLS_W-1:0] detClass
);
  ctrlStrobe_t strobe;
  logic        budgetOk;

  searchCtrl #(.EVT_W(EVT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .psEnable(psEnable), .portReady(portReady),
    .powerApplied(powerApplied), .detDone(detDone), .detTimerDone(detTimerDone),
    .cc2detDone(cc2detDone), .backoffDone(backoffDone), .errDelayDone(errDelayDone),
    .sigCode(sigCode), .altB(altB), .classEvents(classEvents), .budgetOk(budgetOk),
    .strobe(strobe), .detRequest(detRequest), .powerGrant(powerGrant),
    .powerDeny(powerDeny)
  );

  searchDatapath #(.PWR_W(PWR_W), .CLS_W(CLS_W), .DEFAULT_REQ(DEFAULT_REQ)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pdReqValid(pdReqValid),
    .pdReqPower(pdReqPower), .pdClass(pdClass), .availPower(availPower),
    .budgetOk(budgetOk), .startDetTimer(startDetTimer), .stopCc2det(stopCc2det),
    .startPonTimer(startPonTimer), .startBackoffTimer(startBackoffTimer),
    .failFlag(failFlag), .validSig(validSig), .reqPower(reqPower),
    .detClass(detClass)
  );
endmodule

// File: rtl/pairSearchChecker.sv
module pairSearchChecker (
  input logic clk,
  input logic rstN,
  input logic psEnable,
  input logic detRequest,
  input logic startDetTimer,
  input logic stopCc2det,
  input logic startPonTimer,
  input logic failFlag,
  input logic powerGrant,
  input logic powerDeny
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    startDetTimer |=> !startDetTimer);

  assert_stop_with_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detRequest) |-> stopCc2det);

  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failFlag) |-> startPonTimer);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(powerGrant && powerDeny));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> (!detRequest && !powerGrant && !powerDeny));

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !psEnable |=> (!powerGrant && !powerDeny && !detRequest));
endmodule

bind pairSearch pairSearchChecker i_pairSearchChecker (
  .clk(clk), .rstN(rstN), .psEnable(psEnable), .detRequest(detRequest),
  .startDetTimer(startDetTimer), .stopCc2det(stopCc2det),
  .startPonTimer(startPonTimer), .failFlag(failFlag),
  .powerGrant(powerGrant), .powerDeny(powerDeny)
);

// File: tb/test_pairSearch.sv
module test_pairSearch;
  localparam int CLK_PERIOD = 10;
  localparam int PWR_W = 8;
  localparam int CLS_W = 3;
  localparam int EVT_W = 3;
  localparam int OUT_GRANT = 0, OUT_DENY = 1, OUT_BACKOFF = 2, OUT_FAIL = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psEnable = 0, portReady = 0, powerApplied = 0, detDone = 0;
  logic detTimerDone = 0, cc2detDone = 0, backoffDone = 0, errDelayDone = 0;
  logic [1:0] sigCode = 0;
  logic altB = 0;
  logic [EVT_W-1:0] classEvents = 0;
  logic pdReqValid = 0;
  logic [PWR_W-1:0] pdReqPower = 0, availPower = 0;
  logic [CLS_W-1:0] pdClass = 0;
  logic detRequest, startDetTimer, stopCc2det, startPonTimer, startBackoffTimer;
  logic failFlag, validSig, powerGrant, powerDeny;
  logic [PWR_W-1:0] reqPower;
  logic [CLS_W-1:0] detClass;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pairSearch #(.PWR_W(PWR_W), .CLS_W(CLS_W), .EVT_W(EVT_W)) i_pairSearch (
    .clk(clk), .rstN(rstN), .psEnable(psEnable), .portReady(portReady),
    .powerApplied(powerApplied), .detDone(detDone), .detTimerDone(detTimerDone),
    .cc2detDone(cc2detDone), .backoffDone(backoffDone), .errDelayDone(errDelayDone),
    .sigCode(sigCode), .altB(altB), .classEvents(classEvents),
    .pdReqValid(pdReqValid), .pdReqPower(pdReqPower), .pdClass(pdClass),
    .availPower(availPower), .detRequest(detRequest), .startDetTimer(startDetTimer),
    .stopCc2det(stopCc2det), .startPonTimer(startPonTimer),
    .startBackoffTimer(startBackoffTimer), .failFlag(failFlag), .validSig(validSig),
    .powerGrant(powerGrant), .powerDeny(powerDeny), .reqPower(reqPower),
    .detClass(detClass)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expOutcome(input int sig, input bit b, input int ev,
                                    input int avail, input int req, input bit err);
    if (sig != 1) return (b && sig != 2) ? OUT_BACKOFF : OUT_FAIL;
    if (req <= avail && err) return OUT_GRANT;
    return OUT_DENY;
  endfunction

  function automatic bit expFast(input int sig, input int ev, input int avail,
                                 input int req, input bit err);
    return (sig == 1) && (ev == 0) && (avail >= req) && err;
  endfunction

  task automatic runTrial(input int sig, input bit b, input int ev, input int avail,
                          input int req, input int cls, input bit err);
    int outc;
    outc = expOutcome(sig, b, ev, avail, req, err);
    psEnable = 1; portReady = 1; powerApplied = 0;
    step();  // edge 1: detection
    chk("R2", "detRequest", detRequest, 1);
    chk("R2", "startDetTimer", startDetTimer, 1);
    chk("R2", "stopCc2det", stopCc2det, 1);
    chk("R2", "reqPower default", reqPower, 2);
    chk("R2", "detClass cleared", detClass, 0);
    portReady = 0; detDone = 1; sigCode = 2'(sig); altB = b;
    classEvents = EVT_W'(ev); availPower = PWR_W'(avail); errDelayDone = err;
    pdReqValid = 1; pdReqPower = PWR_W'(req); pdClass = CLS_W'(cls);
    step();  // edge 2: evaluation
    chk("R3", "startPonTimer", startPonTimer, 1);
    chk("R3", "failFlag cleared", failFlag, 0);
    chk("R3", "startDetTimer single", startDetTimer, 0);
    chk("R9", "reqPower loaded", reqPower, req);
    chk("R9", "detClass loaded", detClass, cls);
    detDone = 0; pdReqValid = 0;
    step();  // edge 3
    chk("R5", "fast grant", powerGrant, int'(expFast(sig, ev, avail, req, err)));
    chk("R10", "validSig", validSig, int'(sig == 1));
    step();  // edge 4
    chk("R6", "powerGrant", powerGrant, int'(outc == OUT_GRANT));
    chk("R6", "powerDeny", powerDeny, int'(outc == OUT_DENY));
    chk("R4", "startBackoffTimer", startBackoffTimer, int'(outc == OUT_BACKOFF));
    chk("R7", "failFlag", failFlag, int'(outc == OUT_FAIL));
    psEnable = 0;
    step();  // edge 5
    chk("R8", "grant after disable", powerGrant, 0);
    chk("R8", "deny after disable", powerDeny, 0);
    chk("R10", "validSig cleared in idle", validSig, 0);
    step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    rstN = 1;
    step();
    chk("R1", "detRequest", detRequest, 0);
    chk("R1", "powerGrant", powerGrant, 0);
    chk("R1", "powerDeny", powerDeny, 0);
    chk("R1", "failFlag", failFlag, 0);
    chk("R1", "validSig", validSig, 0);
    chk("R1", "reqPower", reqPower, 2);

    // power already applied holds idle
    psEnable = 1; portReady = 1; powerApplied = 1;
    step(); step();
    chk("R1", "stay idle when powered", detRequest, 0);
    powerApplied = 0; portReady = 0; psEnable = 0;
    step();
    chk("R1", "stay idle when not ready", detRequest, 0);

    // window expiry from idle
    psEnable = 1; cc2detDone = 1;
    step();
    chk("R7", "cc2det sets flag", failFlag, 1);
    cc2detDone = 0;
    step(); step();
    chk("R7", "flag latched", failFlag, 1);
    chk("R7", "back in idle", detRequest, 0);
    psEnable = 0;
    step();

    // directed corners
    runTrial(1, 0, 0, 10, 10, 3, 1);   // equal budget fast path
    runTrial(1, 0, 1, 10, 10, 4, 1);   // class path grant
    runTrial(1, 0, 0, 9, 10, 2, 1);    // over budget deny
    runTrial(1, 0, 0, 200, 5, 1, 0);   // timer not done deny
    runTrial(2, 1, 0, 50, 5, 0, 1);    // open on B fails
    runTrial(3, 1, 0, 50, 5, 0, 1);    // code 3 on B backs off
    runTrial(0, 0, 0, 50, 5, 0, 1);    // invalid on A fails

    for (int t = 0; t < 40; t++) begin
      int s, e, a, r;
      bit b, er;
      s = $urandom % 4; b = 1'($urandom % 2); e = $urandom % 3;
      a = $urandom % 256; r = $urandom % 256; er = 1'($urandom % 2);
      if ($urandom % 2 == 0 && r > a) begin int tmp = r; r = a; a = tmp; end
      runTrial(s, b, e, a, r, $urandom % 8, er);
    end

    // detection timer expiry
    psEnable = 1; portReady = 1;
    step();
    portReady = 0; detTimerDone = 1;
    step();
    chk("R7", "det timer sets flag", failFlag, 1);
    chk("R7", "request dropped", detRequest, 0);
    detTimerDone = 0;
    step(); step();
    chk("R7", "flag held", failFlag, 1);

    // backoff returns to idle
    psEnable = 1; portReady = 1; step();
    portReady = 0; detDone = 1; sigCode = 0; altB = 1;
    step(); detDone = 0;
    step(); step();
    chk("R4", "backoff strobe", startBackoffTimer, 1);
    step(); step();
    chk("R4", "waits in backoff", detRequest, 0);
    backoffDone = 1;
    step();
    backoffDone = 0; portReady = 1;
    step();
    chk("R4", "restart after backoff", detRequest, 1);
    psEnable = 0; portReady = 0;
    step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule